// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Registers

This block performs 32-bit integer multiplication and division beside a processor pipeline, one result bit per clock. A start command carries a 6-bit function code and two operands. The unit then works for a fixed number of cycles and leaves its answer in two dedicated 32-bit result registers, HI and LO. The rest of the pipeline may keep issuing unrelated work in the meantime.

Reading a result register is interlocked. A read request made while an operation is still running raises a stall output until the result is ready. A read made while the unit is idle returns the register contents in the same cycle. A new start command issued while an operation is running abandons that operation and begins the new one.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero, and both busy_o and stall_o are low.
- R2: start_i is accepted only with one of these function codes:
  - 0x18: signed multiply.
  - 0x19: unsigned multiply.
  - 0x1A: signed divide.
  - 0x1B: unsigned divide.
  
  A start with any other code is ignored: busy_o stays low and HI/LO keep their values.
- R3: A multiply writes the upper 32 bits of the 64-bit product to HI and the lower 32 bits to LO. Both operands are two's complement for 0x18 and unsigned for 0x19.
- R4: A divide writes the quotient to LO and the remainder to HI. A signed divide truncates the quotient toward zero and gives the remainder the sign of the dividend. The case 0x80000000 / -1 yields quotient 0x80000000 and remainder 0.
- R5: busy_o rises in the cycle after a start is accepted and stays high for exactly 33 cycles (1 setup cycle plus 32 iteration cycles). HI and LO take the new result at the same edge where busy_o falls.
- R6: A read request returns data on rd_data_o in the same cycle:
  - rd_func_i = 0x10 returns HI.
  - rd_func_i = 0x12 returns LO.
  - Any other code, or no request, returns zero.
  
  stall_o is high exactly when a 0x10 or 0x12 request is made while busy_o is high.
- R7: Division by zero completes in the normal time, with no error indication. It leaves all ones in LO and the unmodified dividend in HI, for both the signed and the unsigned divide.
- R8: A valid start accepted while busy_o is high aborts the running operation. The 33-cycle count restarts from that start, and the result written is the one for the new operands.
- R9: HI and LO change only at the completion of an operation. They hold their values while an operation runs and while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command strobe |
| func_i | input | 6 | Operation function code for start_i |
| op_a_i | input | 32 | First operand (multiplicand or dividend) |
| op_b_i | input | 32 | Second operand (multiplier or divisor) |
| rd_req_i | input | 1 | Result read request |
| rd_func_i | input | 6 | Read function code (0x10 HI, 0x12 LO) |
| rd_data_o | output | 32 | Read data |
| stall_o | output | 1 | Read must wait: operation still running |
| busy_o | output | 1 | An operation is in progress |

## Verification
The multiply checks include operands with mixed signs and full-scale values such as 0xFFFFFFFF squared and 0x80000000 squared. Reading these back as signed and as unsigned separates the two sign treatments and exposes a wrong carry into HI.

The divide checks pair negative dividends with positive divisors and the reverse. These cases tell apart a quotient that truncates toward zero from one that floors, and a remainder that follows the dividend's sign from one that follows the divisor's. The 0x80000000 / -1 case and zero divisors exercise the edges of the sign correction.

An invalid function code, a restart partway through an operation, and reads at idle versus busy times separate correct acceptance, abort and interlock behaviour from results that happen to look right.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

  localparam logic [5:0] FN_MFHI  = 6'h10;
  localparam logic [5:0] FN_MFLO  = 6'h12;
  localparam logic [5:0] FN_MULS  = 6'h18;
  localparam logic [5:0] FN_MULU  = 6'h19;
  localparam logic [5:0] FN_DIVS  = 6'h1A;
  localparam logic [5:0] FN_DIVU  = 6'h1B;

  typedef enum logic [1:0] {OP_MULS, OP_MULU, OP_DIVS, OP_DIVU} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_RUN} phase_e;

  function automatic logic fn_valid(input logic [5:0] fn);
    return (fn == FN_MULS) || (fn == FN_MULU) || (fn == FN_DIVS) || (fn == FN_DIVU);
  endfunction

  function automatic op_e fn_to_op(input logic [5:0] fn);
    op_e r;
    case (fn)
      FN_MULU: r = OP_MULU;
      FN_DIVS: r = OP_DIVS;
      FN_DIVU: r = OP_DIVU;
      default: r = OP_MULS;
    endcase
    return r;
  endfunction

  function automatic logic op_signed(input op_e op);
    return (op == OP_MULS) || (op == OP_DIVS);
  endfunction

  function automatic logic op_is_div(input op_e op);
    return (op == OP_DIVS) || (op == OP_DIVU);
  endfunction

endpackage

// File: rtl/muldiv_seq.sv
`timescale 1ns/1ps
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic setup_o,
  output logic run_o,
  output logic last_o,
  output logic busy_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (accept_i) begin
      phase_q <= PH_SETUP;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_SETUP: begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
        end
        PH_RUN: begin
          if (cnt_q == CNT_LAST) phase_q <= PH_IDLE;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign setup_o = (phase_q == PH_SETUP);
  assign run_o   = (phase_q == PH_RUN);
  assign last_o  = run_o && (cnt_q == CNT_LAST);
  assign busy_o  = (phase_q != PH_IDLE);

endmodule

// File: rtl/muldiv_core.sv
`timescale 1ns/1ps
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         setup_i,
  input  logic         run_i,
  output logic [W-1:0] wb_hi_o,
  output logic [W-1:0] wb_lo_o
);
  localparam int PW = 2 * W;

  op_e          op_q;
  logic [W-1:0] a_q, b_q, mag_b_q;
  logic [W:0]   up_q;
  logic [W-1:0] lo_q;
  logic         neg_res_q, neg_rem_q, zdiv_q;

  logic [W:0]   up_n;
  logic [W-1:0] lo_n;

  // one shift-add multiply step on the {upper, lower} working pair
  function automatic logic [PW:0] mul_step(input logic [W:0] up, input logic [W-1:0] lo,
                                           input logic [W-1:0] m);
    logic [W:0] sum;
    sum = lo[0] ? (up + {1'b0, m}) : up;
    return {1'b0, sum, lo} >> 1;
  endfunction

  // one restoring divide step: remainder in upper, quotient shifting into lower
  function automatic logic [PW:0] div_step(input logic [W:0] up, input logic [W-1:0] lo,
                                           input logic [W-1:0] d);
    logic [W:0]   r;
    logic [W-1:0] q;
    r = {up[W-1:0], lo[W-1]};
    q = {lo[W-2:0], 1'b0};
    if (r >= {1'b0, d}) begin
      r    = r - {1'b0, d};
      q[0] = 1'b1;
    end
    return {r, q};
  endfunction

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    if (op_is_div(op_q)) {up_n, lo_n} = div_step(up_q, lo_q, mag_b_q);
    else                 {up_n, lo_n} = mul_step(up_q, lo_q, mag_b_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= OP_MULS;
      a_q       <= '0;
      b_q       <= '0;
      mag_b_q   <= '0;
      up_q      <= '0;
      lo_q      <= '0;
      neg_res_q <= 1'b0;
      neg_rem_q <= 1'b0;
      zdiv_q    <= 1'b0;
    end else if (accept_i) begin
      op_q <= op_i;
      a_q  <= a_i;
      b_q  <= b_i;
    end else if (setup_i) begin
      mag_b_q   <= magnitude(b_q, op_signed(op_q) & b_q[W-1]);
      lo_q      <= magnitude(a_q, op_signed(op_q) & a_q[W-1]);
      up_q      <= '0;
      neg_res_q <= op_signed(op_q) & (a_q[W-1] ^ b_q[W-1]);
      neg_rem_q <= op_signed(op_q) & a_q[W-1];
      zdiv_q    <= (b_q == '0);
    end else if (run_i) begin
      up_q <= up_n;
      lo_q <= lo_n;
    end
  end

  // final values, valid in the last iteration cycle
  logic [PW-1:0] prod_mag, prod;
  always_comb begin
    prod_mag = {up_n[W-1:0], lo_n};
    prod     = neg_res_q ? (~prod_mag + 1'b1) : prod_mag;
    if (op_is_div(op_q)) begin
      if (zdiv_q) begin
        wb_lo_o = '1;
        wb_hi_o = a_q;
      end else begin
        wb_lo_o = magnitude(lo_n, neg_res_q);
        wb_hi_o = magnitude(up_n[W-1:0], neg_rem_q);
      end
    end else begin
      wb_hi_o = prod[PW-1:W];
      wb_lo_o = prod[W-1:0];
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         rd_req_i,
  input  logic [5:0]   rd_func_i,
  output logic [W-1:0] rd_data_o,
  output logic         stall_o,
  output logic         busy_o
);
  logic         accept_w, setup_w, run_w, last_w, done_w;
  logic [W-1:0] wb_hi_w, wb_lo_w;
  logic [W-1:0] hi_q, lo_q;
  logic         rd_hi_w, rd_lo_w;

  assign accept_w = start_i && fn_valid(func_i);
  assign done_w   = last_w && !accept_w;

  muldiv_seq #(.W(W)) seq_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w),
    .setup_o(setup_w), .run_o(run_w), .last_o(last_w), .busy_o(busy_o)
  );

  muldiv_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .op_i(fn_to_op(func_i)),
    .a_i(op_a_i), .b_i(op_b_i), .setup_i(setup_w), .run_i(run_w),
    .wb_hi_o(wb_hi_w), .wb_lo_o(wb_lo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (done_w) begin
      hi_q <= wb_hi_w;
      lo_q <= wb_lo_w;
    end
  end

  assign rd_hi_w   = rd_req_i && (rd_func_i == FN_MFHI);
  assign rd_lo_w   = rd_req_i && (rd_func_i == FN_MFLO);
  assign rd_data_o = rd_hi_w ? hi_q : (rd_lo_w ? lo_q : '0);
  assign stall_o   = (rd_hi_w || rd_lo_w) && busy_o;

endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept_w,
  input logic         done_w,
  input logic         busy_o,
  input logic         stall_o,
  input logic         rd_req_i,
  input logic [5:0]   rd_func_i,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  logic [7:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n || accept_w) busy_len <= '0;
    else if (busy_o)        busy_len <= busy_len + 1'b1;
  end

  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o);

  p_done_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> (busy_len == 8'(W)));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !busy_o);

  p_stall_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && busy_o && (rd_func_i == 6'h10 || rd_func_i == 6'h12)) |-> stall_o);

  p_no_stall_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !stall_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept_w(accept_w), .done_w(done_w),
  .busy_o(busy_o), .stall_o(stall_o), .rd_req_i(rd_req_i), .rd_func_i(rd_func_i),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  func_i = '0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic        rd_req_i = 1'b0;
  logic [5:0]  rd_func_i = '0;
  logic [31:0] rd_data_o;
  logic        stall_o, busy_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .rd_req_i(rd_req_i), .rd_func_i(rd_func_i),
    .rd_data_o(rd_data_o), .stall_o(stall_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from native arithmetic on 64-bit values
  task automatic model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] eh, output logic [31:0] el);
    longint sa, sb, r;
    longint unsigned ua, ub, ur;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (fn)
      6'h18: begin r = sa * sb; {eh, el} = r; end
      6'h19: begin ur = ua * ub; {eh, el} = ur; end
      6'h1A: begin
        if (b == 0) begin el = '1; eh = a; end
        else begin r = sa / sb; el = r[31:0]; r = sa % sb; eh = r[31:0]; end
      end
      default: begin
        if (b == 0) begin el = '1; eh = a; end
        else begin ur = ua / ub; el = ur[31:0]; ur = ua % ub; eh = ur[31:0]; end
      end
    endcase
  endtask

  task automatic read_reg(input logic [5:0] fn, output logic [31:0] d, output logic st);
    rd_req_i  = 1'b1;
    rd_func_i = fn;
    #1;
    d  = rd_data_o;
    st = stall_o;
    rd_req_i = 1'b0;
  endtask

  task automatic issue(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start_i = 1'b1; func_i = fn; op_a_i = a; op_b_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // counts busy cycles from the current negedge until busy falls
  task automatic wait_done(output int n);
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input string tag, input logic [5:0] fn,
                              input logic [31:0] a, input logic [31:0] b);
    logic [31:0] eh, el, d;
    logic st;
    model(fn, a, b, eh, el);
    read_reg(6'h10, d, st);
    check({tag, " HI"}, d, eh);
    check({tag, " no stall idle R6"}, {31'd0, st}, 32'd0);
    read_reg(6'h12, d, st);
    check({tag, " LO"}, d, el);
  endtask

  task automatic run_op(input string tag, input logic [5:0] fn,
                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    logic st;
    int n;
    issue(fn, a, b);
    check({tag, " R5 busy after start"}, {31'd0, busy_o}, 32'd1);
    read_reg(6'h12, d, st);
    check({tag, " R6 stall while busy"}, {31'd0, st}, 32'd1);
    wait_done(n);
    check({tag, " R5 busy length"}, n, 33);
    check_result(tag, fn, a, b);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic st;
    read_reg(6'h10, d, st);
    check("R1 HI after reset", d, 32'd0);
    read_reg(6'h12, d, st);
    check("R1 LO after reset", d, 32'd0);
    check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
    check("R1 stall after reset", {31'd0, st}, 32'd0);
  endtask

  task automatic t_mul;
    run_op("R3 signed mul mixed", 6'h18, 32'hFFFF_FFF9, 32'd9);
    run_op("R3 unsigned mul full", 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R3 signed mul full", 6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R3 signed mul min", 6'h18, 32'h8000_0000, 32'h8000_0000);
    run_op("R3 unsigned mul pattern", 6'h19, 32'h1234_5678, 32'h9ABC_DEF0);
  endtask

  task automatic t_div;
    run_op("R4 signed div neg dividend", 6'h1A, 32'hFFFF_FFEF, 32'd5);
    run_op("R4 signed div neg divisor", 6'h1A, 32'd17, 32'hFFFF_FFFB);
    run_op("R4 unsigned div", 6'h1B, 32'hFFFF_FFFF, 32'd7);
    run_op("R4 signed min by -1", 6'h1A, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R4 unsigned small by large", 6'h1B, 32'd3, 32'h8000_0000);
  endtask

  task automatic t_divzero;
    run_op("R7 signed div by zero", 6'h1A, 32'hFFFF_FF00, 32'd0);
    run_op("R7 unsigned div by zero", 6'h1B, 32'h0000_1234, 32'd0);
  endtask

  task automatic t_invalid;
    logic [31:0] eh, el;
    model(6'h1B, 32'h0000_1234, 32'd0, eh, el);
    issue(6'h20, 32'd5, 32'd6);
    check("R2 invalid code no busy", {31'd0, busy_o}, 32'd0);
    check_result("R2 invalid code keeps", 6'h1B, 32'h0000_1234, 32'd0);
    issue(6'h11, 32'd5, 32'd6);
    check("R2 code 0x11 no busy", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic t_restart;
    logic [31:0] d, eh0, el0;
    logic st;
    int n;
    model(6'h1B, 32'h0000_1234, 32'd0, eh0, el0);
    issue(6'h19, 32'd1000, 32'd3000);
    repeat (10) @(negedge clk);
    issue(6'h1A, 32'hFFFF_FF9C, 32'd7);
    read_reg(6'h10, d, st);
    check("R8 HI held after restart R9", d, eh0);
    wait_done(n);
    check("R8 busy length from restart", n, 33);
    check_result("R8 restart result", 6'h1A, 32'hFFFF_FF9C, 32'd7);
  endtask

  task automatic t_readsel;
    logic [31:0] d;
    logic st;
    read_reg(6'h11, d, st);
    check("R6 other read code zero", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul();
    t_div();
    t_divzero();
    t_invalid();
    t_restart();
    t_readsel();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule